// File: doc/BRIEF.md
# Program Counter and Status Register Unit

This block keeps the processor's combined program-counter/status word: a 32-bit register holding a 24-bit word-aligned fetch address, the four condition flags, two interrupt-mask bits and a two-bit processor mode. The block sits between instruction decode, the ALU and the barrel shifter. Each cycle it presents a view of this word to whichever operand port asks for it. When a data-processing instruction completes, it applies the write-back rules for the word.

What is written depends on four things: whether the destination index names the PC/status register (index 15), the S bit, whether the opcode is result-producing or a compare/test, and whether the current mode is user mode. What is read depends on the operand port and on whether the shift amount comes from the instruction or from a register. When no write-back targets the PC, the PC advances by one word on each fetch.

Top module: `pcsr_unit`

## Requirements
- R1: Reset sets the PC field and condition flags to zero, sets both interrupt-mask bits to 1, and sets the mode to RESET_MODE (default 2'b11, privileged).
- R2: With exValid high, a destination index other than 15 and S set, the condition flags take aluFlags on the next edge. The masks and the mode keep their values.
- R3: With exValid high, a destination index other than 15 and S clear, no status bit changes.
- R4: With exValid high, destination 15, S clear and a result-producing opcode, the PC takes resultBus[25:2] on the next edge. All status bits keep their values.
- R5: With destination 15, S set and mode 2'b00 (user), the condition flags take resultBus[31:28]. The masks and the mode are left untouched. A result-producing opcode also loads the PC from resultBus[25:2].
- R6: With destination 15, S set and a mode other than 2'b00, the condition flags are loaded as in R5. In addition, irqMask takes resultBus[27], fiqMask takes resultBus[26] and the mode takes resultBus[1:0].
- R7: A compare/test opcode never writes the PC; the PC follows R11 instead. With destination 15 and S set, such an opcode still updates the status bits according to R5/R6. With S clear, it changes nothing.
- R8: With portSel = 0 (Rm), operandOut is {flags, irqMask, fiqMask, pcView, mode}. Here pcView occupies bits 25:2.
- R9: With portSel = 1 (Rn), 2 (Rs) or 3 (treated as Rn), operandOut carries pcView in bits 25:2 and zeros in bits 31:26 and 1:0.
- R10: pcView is instrAddr[25:2] + 2 words (8 bytes) when regShift is 0 or portSel is 2. It is instrAddr[25:2] + 3 words (12 bytes) when regShift is 1 on any other port. The sum wraps modulo 2^24.
- R11: When fetchEn is high and no PC write occurs, the PC advances by one word, wrapping from 24'hFFFFFF to 0. Otherwise the PC holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| exValid | input | 1 | A data-processing write-back occurs this cycle |
| fetchEn | input | 1 | A fetch occurs this cycle |
| resultBus | input | 32 | ALU result |
| aluFlags | input | 4 | ALU flags N,Z,C,V |
| dstIdx | input | 4 | Destination register index |
| sBit | input | 1 | Set-flags bit of the instruction |
| isCompare | input | 1 | 1 for compare/test opcodes |
| portSel | input | 2 | Operand port: 0 Rm, 1 Rn, 2 Rs |
| regShift | input | 1 | 1 when the shift amount comes from a register |
| instrAddr | input | 26 | Byte address of the current instruction |
| operandOut | output | 32 | PC/status view for the selected port |
| pcWord | output | 24 | PC word address |
| condFlags | output | 4 | N,Z,C,V |
| irqMask | output | 1 | Interrupt mask |
| fiqMask | output | 1 | Fast-interrupt mask |
| modeBits | output | 2 | Processor mode |

## Verification
The write-back rules are swept over every mode, over destinations 3 and 15, over S, over the opcode class and over fetchEn. Each combination is checked against the full word, so the sweep shows which fields each case may touch. The result bus pattern has different values in the flag, mask, PC and mode fields, which makes a field taken from the wrong source or the wrong bit position visible. The operand sweep covers all port codes, both shift sources and addresses near the wrap point, so that the +8/+12 split and the zeroing of status bits per port are told apart.

// File: rtl/pcsr_pkg.sv
package pcsr_pkg;
  localparam int PC_W   = 24;
  localparam int FLAG_W = 4;
  localparam int MODE_W = 2;
  localparam int WORD_W = FLAG_W + 2 + PC_W + MODE_W;
  localparam int ADDR_W = PC_W + 2;
  localparam logic [3:0] PC_INDEX = 4'd15;
  localparam logic [MODE_W-1:0] USER_MODE = '0;
  localparam logic [1:0] PORT_RM = 2'd0;
  localparam logic [1:0] PORT_RS = 2'd2;

  typedef struct packed {
    logic wrPc;
    logic incPc;
    logic wrFlagsAlu;
    logic wrFlagsRes;
    logic wrCtl;
    logic addThree;
  } strobes_t;
endpackage

// File: rtl/pcsr_ctrl.sv
module pcsr_ctrl
  import pcsr_pkg::*;
(
  input  logic              exValid,
  input  logic              fetchEn,
  input  logic [3:0]        dstIdx,
  input  logic              sBit,
  input  logic              isCompare,
  input  logic [1:0]        portSel,
  input  logic              regShift,
  input  logic [MODE_W-1:0] curMode,
  output strobes_t          st
);
  logic toPc;
  logic userMode;

  always_comb begin
    toPc           = (dstIdx == PC_INDEX);
    userMode       = (curMode == USER_MODE);
    st.wrPc        = exValid && toPc && !isCompare;
    st.incPc       = fetchEn && !st.wrPc;
    st.wrFlagsAlu  = exValid && !toPc && sBit;
    st.wrFlagsRes  = exValid && toPc && sBit;
    st.wrCtl       = st.wrFlagsRes && !userMode;
    st.addThree    = regShift && (portSel != PORT_RS);
  end
endmodule

// File: rtl/pcsr_dp.sv
module pcsr_dp
  import pcsr_pkg::*;
#(
  parameter logic [1:0] RESET_MODE = 2'b11
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          st,
  input  logic [WORD_W-1:0] resultBus,
  input  logic [FLAG_W-1:0] aluFlags,
  input  logic [ADDR_W-1:0] instrAddr,
  input  logic [1:0]        portSel,
  output logic [WORD_W-1:0] operandOut,
  output logic [PC_W-1:0]   pcWord,
  output logic [FLAG_W-1:0] condFlags,
  output logic              irqMask,
  output logic              fiqMask,
  output logic [MODE_W-1:0] modeBits
);
  logic [PC_W-1:0] pcView;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcWord    <= '0;
      condFlags <= '0;
      irqMask   <= 1'b1;
      fiqMask   <= 1'b1;
      modeBits  <= RESET_MODE;
    end else begin
      if (st.wrPc)       pcWord <= resultBus[PC_W+1:2];
      else if (st.incPc) pcWord <= pcWord + 1'b1;

      if (st.wrFlagsAlu)      condFlags <= aluFlags;
      else if (st.wrFlagsRes) condFlags <= resultBus[WORD_W-1 -: FLAG_W];

      if (st.wrCtl) begin
        irqMask  <= resultBus[PC_W+3];
        fiqMask  <= resultBus[PC_W+2];
        modeBits <= resultBus[MODE_W-1:0];
      end
    end
  end

  always_comb begin
    pcView = instrAddr[ADDR_W-1:2] + (st.addThree ? PC_W'(3) : PC_W'(2));
    if (portSel == PORT_RM)
      operandOut = {condFlags, irqMask, fiqMask, pcView, modeBits};
    else
      operandOut = {{(FLAG_W+2){1'b0}}, pcView, {MODE_W{1'b0}}};
  end
endmodule

// File: rtl/pcsr_unit.sv
module pcsr_unit
  import pcsr_pkg::*;
#(
  parameter logic [1:0] RESET_MODE = 2'b11
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        exValid,
  input  logic        fetchEn,
  input  logic [31:0] resultBus,
  input  logic [3:0]  aluFlags,
  input  logic [3:0]  dstIdx,
  input  logic        sBit,
  input  logic        isCompare,
  input  logic [1:0]  portSel,
  input  logic        regShift,
  input  logic [25:0] instrAddr,
  output logic [31:0] operandOut,
  output logic [23:0] pcWord,
  output logic [3:0]  condFlags,
  output logic        irqMask,
  output logic        fiqMask,
  output logic [1:0]  modeBits
);
  strobes_t st;

  pcsr_ctrl u_ctrl (
    .exValid(exValid), .fetchEn(fetchEn), .dstIdx(dstIdx), .sBit(sBit),
    .isCompare(isCompare), .portSel(portSel), .regShift(regShift),
    .curMode(modeBits), .st(st)
  );

  pcsr_dp #(.RESET_MODE(RESET_MODE)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .resultBus(resultBus),
    .aluFlags(aluFlags), .instrAddr(instrAddr), .portSel(portSel),
    .operandOut(operandOut), .pcWord(pcWord), .condFlags(condFlags),
    .irqMask(irqMask), .fiqMask(fiqMask), .modeBits(modeBits)
  );
endmodule

// File: rtl/pcsr_chk.sv
module pcsr_chk (
  input logic        clk,
  input logic        rstN,
  input logic        exValid,
  input logic        fetchEn,
  input logic [31:0] resultBus,
  input logic [3:0]  aluFlags,
  input logic [3:0]  dstIdx,
  input logic        sBit,
  input logic        isCompare,
  input logic [1:0]  portSel,
  input logic        regShift,
  input logic [25:0] instrAddr,
  input logic [31:0] operandOut,
  input logic [23:0] pcWord,
  input logic [3:0]  condFlags,
  input logic        irqMask,
  input logic        fiqMask,
  input logic [1:0]  modeBits
);
  a_r2_flags_from_alu: assert property (@(posedge clk) disable iff (!rstN)
    exValid && dstIdx != 4'd15 && sBit |=> condFlags == $past(aluFlags));

  a_r3_status_hold: assert property (@(posedge clk) disable iff (!rstN)
    exValid && dstIdx != 4'd15 && !sBit
    |=> {condFlags, irqMask, fiqMask, modeBits}
        == $past({condFlags, irqMask, fiqMask, modeBits}));

  a_r4_pc_only: assert property (@(posedge clk) disable iff (!rstN)
    exValid && dstIdx == 4'd15 && !sBit && !isCompare
    |=> pcWord == $past(resultBus[25:2])
        && {condFlags, irqMask, fiqMask, modeBits}
           == $past({condFlags, irqMask, fiqMask, modeBits}));

  a_r5_user_protect: assert property (@(posedge clk) disable iff (!rstN)
    exValid && modeBits == 2'b00
    |=> {irqMask, fiqMask, modeBits} == $past({irqMask, fiqMask, modeBits}));

  a_r6_priv_load: assert property (@(posedge clk) disable iff (!rstN)
    exValid && dstIdx == 4'd15 && sBit && modeBits != 2'b00
    |=> {irqMask, fiqMask} == $past(resultBus[27:26])
        && modeBits == $past(resultBus[1:0]));

  a_r7_cmp_no_pc: assert property (@(posedge clk) disable iff (!rstN)
    exValid && isCompare && !fetchEn |=> pcWord == $past(pcWord));

  a_r8_rm_view: assert property (@(posedge clk) disable iff (!rstN)
    portSel == 2'd0
    |-> operandOut[31:26] == {condFlags, irqMask, fiqMask}
        && operandOut[1:0] == modeBits);

  a_r9_zeroed_view: assert property (@(posedge clk) disable iff (!rstN)
    portSel != 2'd0 |-> operandOut[31:26] == 6'd0 && operandOut[1:0] == 2'd0);

  a_r10_imm_offset: assert property (@(posedge clk) disable iff (!rstN)
    !regShift |-> operandOut[25:2] == 24'(instrAddr[25:2] + 24'd2));

  a_r11_fetch_step: assert property (@(posedge clk) disable iff (!rstN)
    fetchEn && !(exValid && dstIdx == 4'd15 && !isCompare)
    |=> pcWord == 24'($past(pcWord) + 24'd1));
endmodule

bind pcsr_unit pcsr_chk u_chk (.*);

// File: tb/sim_pcsr_unit.sv
module sim_pcsr_unit;
  logic        clk = 1'b0;
  logic        rstN, exValid, fetchEn, sBit, isCompare, regShift;
  logic [31:0] resultBus;
  logic [3:0]  aluFlags, dstIdx;
  logic [1:0]  portSel;
  logic [25:0] instrAddr;
  logic [31:0] operandOut;
  logic [23:0] pcWord;
  logic [3:0]  condFlags;
  logic        irqMask, fiqMask;
  logic [1:0]  modeBits;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [23:0] ePc;
  logic [3:0]  eFl;
  logic        eI, eF;
  logic [1:0]  eMode;

  always #2.5ns clk = ~clk;

  pcsr_unit u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] curWord();
    return {condFlags, irqMask, fiqMask, pcWord, modeBits};
  endfunction

  function automatic logic [31:0] expWord();
    return {eFl, eI, eF, ePc, eMode};
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; exValid = 1'b0; fetchEn = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    ePc = '0; eFl = '0; eI = 1'b1; eF = 1'b1; eMode = 2'b11;
  endtask

  // Drives one cycle at negedge, updates model from requirements, resamples at next negedge.
  task automatic step(input logic ex, input logic fe, input logic [3:0] d,
                      input logic s, input logic c, input logic [31:0] res,
                      input logic [3:0] alu);
    logic pcWr;
    exValid = ex; fetchEn = fe; dstIdx = d; sBit = s; isCompare = c;
    resultBus = res; aluFlags = alu;
    @(posedge clk);
    pcWr = ex && d == 4'd15 && !c;
    if (ex && d != 4'd15 && s) eFl = alu;
    if (ex && d == 4'd15 && s) begin
      eFl = res[31:28];
      if (eMode != 2'b00) begin
        eI = res[27]; eF = res[26]; eMode = res[1:0];
      end
    end
    if (pcWr) ePc = res[25:2];
    else if (fe) ePc = ePc + 24'd1;
    @(negedge clk);
    exValid = 1'b0; fetchEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements) act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    string tag;
    rstN = 1'b0; exValid = 1'b0; fetchEn = 1'b0; dstIdx = '0; sBit = 1'b0;
    isCompare = 1'b0; resultBus = '0; aluFlags = '0; portSel = '0;
    regShift = 1'b0; instrAddr = '0;

    doReset();
    chk("R1 reset word", curWord(), {4'h0, 1'b1, 1'b1, 24'h0, 2'b11});

    // Write-back sweep: mode x destination x S x opcode class x fetch.
    for (int m = 0; m < 4; m++)
      for (int di = 0; di < 2; di++)
        for (int s = 0; s < 2; s++)
          for (int c = 0; c < 2; c++)
            for (int f = 0; f < 2; f++) begin
              logic [31:0] pat;
              doReset();
              if (m != 3) begin
                step(1'b1, 1'b0, 4'd15, 1'b1, 1'b0,
                     {4'h6, 2'b01, 24'h123456, 2'(m)}, 4'h0);
                chk("R6 mode setup", curWord(), expWord());
              end
              pat = {4'(9 + m), 2'(s + 2 * c), 24'hA5C30F ^ 24'(di * 24'h111), 2'(3 - m)};
              step(1'b1, 1'(f), di ? 4'd15 : 4'd3, 1'(s), 1'(c), pat, 4'(m * 5 + 2));
              if (di == 0)      tag = s ? "R2 flags from ALU" : "R3 status held";
              else if (c == 1)  tag = "R7 compare to PC/status";
              else if (s == 0)  tag = "R4 PC only";
              else if (m == 0)  tag = "R5 user protect";
              else              tag = "R6 privileged load";
              chk(tag, curWord(), expWord());
            end

    // Fetch increment and wrap.
    doReset();
    step(1'b1, 1'b0, 4'd15, 1'b0, 1'b0, 32'h03FF_FFF8, 4'h0);
    chk("R4 PC near top", {8'h0, pcWord}, 32'h00FF_FFFE);
    step(1'b0, 1'b1, 4'd0, 1'b0, 1'b0, 32'h0, 4'h0);
    chk("R11 fetch step", {8'h0, pcWord}, 32'h00FF_FFFF);
    step(1'b0, 1'b1, 4'd0, 1'b0, 1'b0, 32'h0, 4'h0);
    chk("R11 fetch wrap", {8'h0, pcWord}, 32'h0);
    step(1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 32'h0, 4'h0);
    chk("R11 hold without fetch", {8'h0, pcWord}, 32'h0);
    step(1'b1, 1'b1, 4'd15, 1'b0, 1'b0, 32'h0000_0100, 4'h0);
    chk("R11 write beats fetch", {8'h0, pcWord}, 32'h40);

    // Operand sweep with a non-trivial status word.
    step(1'b1, 1'b0, 4'd15, 1'b1, 1'b1, {4'hB, 2'b10, 24'h0, 2'b10}, 4'h0);
    chk("R7 compare status load", curWord(), expWord());
    for (int a = 0; a < 4; a++)
      for (int p = 0; p < 4; p++)
        for (int r = 0; r < 2; r++) begin
          logic [23:0] view;
          logic [31:0] exp;
          logic [25:0] addrs [4];
          addrs[0] = 26'h0; addrs[1] = 26'h0001234;
          addrs[2] = 26'h3FFFFF8; addrs[3] = 26'h3FFFFFC;
          instrAddr = addrs[a]; portSel = 2'(p); regShift = 1'(r);
          #1ns;
          view = addrs[a][25:2] + ((r == 1 && p != 2) ? 24'd3 : 24'd2);
          exp = (p == 0) ? {eFl, eI, eF, view, eMode} : {6'd0, view, 2'd0};
          if (p == 0)      tag = "R8/R10 Rm view";
          else             tag = "R9/R10 zeroed view";
          chk(tag, operandOut, exp);
        end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule